// File: doc/BRIEF.md
# MESI Snooping L1 Cache Controller

This block keeps the tag and coherence state of one private, write-back, direct-mapped first-level cache of 256 bytes in 64-byte blocks (4 sets). A processor presents a load or store on a 20-bit byte address. The block looks the address up and either finishes the access at once or asks the shared coherence bus for a read, a read-for-ownership or an upgrade. Before the new request it writes a dirty victim back. The data array itself is out of scope. A writeback is shown as a bus command, and a snooped dirty line raises a flush pulse.

The processor holds `cpu_valid`, `cpu_we` and `cpu_addr` steady until `cpu_done` pulses. The bus side raises `bus_req` and waits for `bus_grant`. The caller never presents a snoop in a cycle where this cache is granted. Every other cache's transaction is shown on the snoop port for one cycle. The snoop port answers in the same cycle with a shared and a flush indication, and the line's state changes at the next clock edge. When a snoop and a new processor request arrive in the same cycle, the snoop is handled first. Command encoding on both ports: 00 read, 01 read-for-ownership, 10 upgrade, 11 writeback.

Top module: `mesi_l1_ctrl`

## Requirements
- R1: After reset every line is Invalid. Any access misses, and no snoop gets a shared or flush response.
- R2: The address splits into bits [5:0] offset, [7:6] set index and [19:8] tag. Any offset within a held block hits. `bus_addr` always carries a block address with bits [5:0] zero.
- R3: A load miss requests command 00. When granted, the line fills Exclusive if `bus_shared_in` is low and Shared if it is high. `cpu_done` pulses in the cycle after the grant.
- R4: A store miss requests command 01, and the line becomes Modified when granted.
- R5: A load hit in any valid state, or a store hit in Exclusive or Modified, makes no bus request. `cpu_done` pulses one cycle after acceptance. A store to an Exclusive line moves it to Modified without bus traffic.
- R6: A store hit on a Shared line requests command 10 and becomes Modified. If a snoop invalidates the line while the request waits, the request turns into command 01.
- R7: A miss whose set holds a Modified line with another tag first requests command 11 at the victim's block address, then issues its own request.
- R8: A snooped read (00) that matches a valid line raises `snp_shared`. A Modified or Exclusive line drops to Shared. A Modified line also raises `snp_flush`.
- R9: A snooped 01 or 10 that matches a valid line moves it to Invalid without `snp_shared`. `snp_flush` is raised only if the line was Modified.
- R10: A snoop with a different tag, to an Invalid line, or with command 11 gives no response and leaves the line unchanged.
- R11: While a read, read-for-ownership or upgrade waits for `bus_grant`, `bus_req` stays high and `bus_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Processor access pending, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 20 | Byte address of the access |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested command (00/01/10/11) |
| bus_addr | output | 20 | Block address of the request |
| bus_grant | input | 1 | Bus granted to the request this cycle |
| bus_shared_in | input | 1 | Another cache holds the block (sampled at grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | 20 | Snooped block address |
| snp_shared | output | 1 | This cache holds the snooped block (reads only) |
| snp_flush | output | 1 | This cache supplies dirty data for the snooped block |

## Verification
The bench drives one line through the full Exclusive, Shared, Modified, Shared, Invalid round. It shows state only through bus commands and snoop responses: a store that wrongly hits a Shared line would show no upgrade, and a missed Exclusive fill would show an extra upgrade. It makes a conflict miss on a dirty set, which a design that skips the writeback or orders it after the fill would show by a missing or late command 11. It invalidates a line while its upgrade waits, so a stale upgrade would appear in place of a read-for-ownership. It also sends snoops with a mismatched tag, to an Invalid line and with the writeback command, all of which must stay silent and leave the next store's behaviour unchanged.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD   = 2'b00,
    CMD_RDX  = 2'b01,
    CMD_UPGR = 2'b10,
    CMD_WB   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int TAG_W    = 12,
  parameter int IDX_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  output line_st_e         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [TAG_W-1:0] rd_b_tag,
  output line_st_e         rd_b_st,
  input  logic             lw_en,
  input  logic [IDX_W-1:0] lw_idx,
  input  logic [TAG_W-1:0] lw_tag,
  input  line_st_e         lw_st,
  input  logic             sw_en,
  input  logic [IDX_W-1:0] sw_idx,
  input  line_st_e         sw_st
);
  logic [TAG_W-1:0] tag_vec [NUM_SETS];
  line_st_e         st_vec  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [TAG_W-1:0] tag_q, tag_d;
    line_st_e         st_q, st_d;
    logic             tag_en, st_en, snp_hit;

    always_comb begin
      snp_hit = sw_en && (sw_idx == IDX_W'(s));
      tag_en  = lw_en && (lw_idx == IDX_W'(s));
      tag_d   = lw_tag;
      st_en   = tag_en || snp_hit;
      st_d    = snp_hit ? sw_st : lw_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        st_q  <= ST_I;
      end else begin
        if (tag_en) tag_q <= tag_d;
        if (st_en)  st_q  <= st_d;
      end
    end

    assign tag_vec[s] = tag_q;
    assign st_vec[s]  = st_q;
  end

  assign rd_a_tag = tag_vec[rd_a_idx];
  assign rd_a_st  = st_vec[rd_a_idx];
  assign rd_b_tag = tag_vec[rd_b_idx];
  assign rd_b_st  = st_vec[rd_b_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             snp_shared,
  output logic             snp_flush,
  output logic             upd_en,
  output line_st_e         upd_st
);
  logic match;

  always_comb begin
    match      = snp_valid && (snp_cmd != CMD_WB) &&
                 (line_st != ST_I) && (line_tag == snp_tag);
    snp_shared = 1'b0;
    snp_flush  = match && (line_st == ST_M);
    upd_en     = 1'b0;
    upd_st     = ST_I;
    if (match) begin
      if (snp_cmd == CMD_RD) begin
        snp_shared = 1'b1;
        upd_en     = (line_st == ST_M) || (line_st == ST_E);
        upd_st     = ST_S;
      end else begin
        upd_en     = 1'b1;
        upd_st     = ST_I;
      end
    end
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int IDX_W = 2,
  parameter int TAG_W = 12,
  parameter int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  input  logic              snp_busy,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  output logic              cpu_done,
  output logic              bus_req,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              lw_en,
  output logic [TAG_W-1:0]  lw_tag,
  output line_st_e          lw_st
);
  typedef enum logic [1:0] {F_IDLE, F_WBACK, F_REQ, F_DONE} fsm_e;

  fsm_e state_q, state_d;
  logic hit;

  always_comb begin
    hit      = (line_st != ST_I) && (line_tag == cpu_tag);
    state_d  = state_q;
    lw_en    = 1'b0;
    lw_tag   = cpu_tag;
    lw_st    = ST_I;
    bus_req  = 1'b0;
    bus_cmd  = CMD_RD;
    bus_addr = {cpu_tag, cpu_idx, {OFF_W{1'b0}}};
    cpu_done = 1'b0;
    case (state_q)
      F_IDLE: begin
        if (cpu_valid && !snp_busy) begin
          if (hit && !cpu_we) begin
            state_d = F_DONE;
          end else if (hit && cpu_we && (line_st == ST_M || line_st == ST_E)) begin
            lw_en   = 1'b1;
            lw_st   = ST_M;
            state_d = F_DONE;
          end else if (!hit && line_st == ST_M) begin
            state_d = F_WBACK;
          end else begin
            state_d = F_REQ;
          end
        end
      end
      F_WBACK: begin
        bus_cmd  = CMD_WB;
        bus_addr = {line_tag, cpu_idx, {OFF_W{1'b0}}};
        if (line_st == ST_M) begin
          bus_req = 1'b1;
          if (bus_grant) begin
            lw_en   = 1'b1;
            lw_tag  = line_tag;
            lw_st   = ST_I;
            state_d = F_REQ;
          end
        end else begin
          state_d = F_REQ;
        end
      end
      F_REQ: begin
        bus_req = 1'b1;
        if (cpu_we) bus_cmd = (hit && line_st == ST_S) ? CMD_UPGR : CMD_RDX;
        if (bus_grant) begin
          lw_en   = 1'b1;
          lw_st   = cpu_we ? ST_M : (bus_shared_in ? ST_S : ST_E);
          state_d = F_DONE;
        end
      end
      default: begin
        cpu_done = 1'b1;
        state_d  = F_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= F_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/mesi_l1_ctrl.sv
module mesi_l1_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_SETS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [TAG_W-1:0] cpu_tag, snp_tag, a_tag, b_tag, lw_tag;
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  line_st_e         a_st, b_st, lw_st, upd_st;
  bus_cmd_e         cmd_w;
  logic             lw_en, upd_en;
  logic             unused_offset;

  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr[OFF_W +: IDX_W];
  assign unused_offset = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  mesi_tag_array #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_a_idx(cpu_idx), .rd_a_tag(a_tag), .rd_a_st(a_st),
    .rd_b_idx(snp_idx), .rd_b_tag(b_tag), .rd_b_st(b_st),
    .lw_en(lw_en), .lw_idx(cpu_idx), .lw_tag(lw_tag), .lw_st(lw_st),
    .sw_en(upd_en), .sw_idx(snp_idx), .sw_st(upd_st)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_tag),
    .line_tag(b_tag), .line_st(b_st),
    .snp_shared(snp_shared), .snp_flush(snp_flush),
    .upd_en(upd_en), .upd_st(upd_st)
  );

  mesi_req_fsm #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
    .line_tag(a_tag), .line_st(a_st), .snp_busy(snp_valid),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(cmd_w), .bus_addr(bus_addr),
    .lw_en(lw_en), .lw_tag(lw_tag), .lw_st(lw_st)
  );

  assign bus_cmd = cmd_w;
endmodule

// File: rtl/mesi_l1_checker.sv
module mesi_l1_checker #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_grant,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_flush
);
  assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[OFF_W-1:0] == '0));

  assert_done_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && bus_cmd != 2'b11) |=> cpu_done);

  assert_done_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_request_after_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && bus_cmd == 2'b11) |=> (bus_req && bus_cmd != 2'b11));

  assert_shared_only_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_cmd == 2'b00));

  assert_flush_needs_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && snp_cmd != 2'b11));

  assert_request_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant && bus_cmd != 2'b11) |=> (bus_req && $stable(bus_addr)));
endmodule

bind mesi_l1_ctrl mesi_l1_checker #(.ADDR_W(ADDR_W), .OFF_W($clog2(BLOCK_BYTES))) u_checker (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .bus_grant(bus_grant), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/test_mesi_l1_ctrl.sv
`timescale 1ns/1ps
module test_mesi_l1_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic        cpu_done, bus_req, snp_shared, snp_flush;
  logic [1:0]  bus_cmd;
  logic [19:0] bus_addr;
  logic        bus_grant = 1'b0, bus_shared_in = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [19:0] snp_addr = '0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mesi_l1_ctrl i_mesi_l1_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

  // {snoop?, cmd/we, shared_in, addr, expect[3:0], writeback addr}
  // CPU expect: {wb_seen, cmd} with cmd 4 = hit.  SNP expect: {2'b0, shared, flush}.
  localparam int NV = 19;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 20'h1FF40, 4'h0, 20'h0},     // R1 snoop after reset
    {1'b0, 2'd0, 1'b0, 20'h1FF40, 4'h0, 20'h0},     // R3 load miss -> E
    {1'b0, 2'd0, 1'b0, 20'h1FF7C, 4'h4, 20'h0},     // R2 other offset hits
    {1'b1, 2'd0, 1'b0, 20'h1FF40, 4'h2, 20'h0},     // R8 E -> S
    {1'b0, 2'd1, 1'b0, 20'h1FF44, 4'h2, 20'h0},     // R6 upgrade -> M
    {1'b1, 2'd0, 1'b0, 20'h1FF48, 4'h3, 20'h0},     // R8 M -> S with flush
    {1'b1, 2'd1, 1'b0, 20'h1FF40, 4'h0, 20'h0},     // R9 S -> I
    {1'b0, 2'd0, 1'b1, 20'h1FF40, 4'h0, 20'h0},     // R3 load miss -> S
    {1'b0, 2'd1, 1'b0, 20'h11080, 4'h1, 20'h0},     // R4 store miss -> M
    {1'b0, 2'd1, 1'b0, 20'h110A0, 4'h4, 20'h0},     // R5 store hit M
    {1'b0, 2'd0, 1'b0, 20'h10F80, 4'h8, 20'h11080}, // R7 dirty victim
    {1'b1, 2'd0, 1'b0, 20'h11080, 4'h0, 20'h0},     // R10 tag mismatch
    {1'b0, 2'd1, 1'b0, 20'h10F90, 4'h4, 20'h0},     // R5 E -> M silently
    {1'b1, 2'd2, 1'b0, 20'h10F80, 4'h1, 20'h0},     // R9 upgrade snoop on M
    {1'b1, 2'd0, 1'b0, 20'h10F80, 4'h0, 20'h0},     // R10 invalid line
    {1'b0, 2'd0, 1'b0, 20'h00000, 4'h0, 20'h0},     // R3 fill E
    {1'b1, 2'd3, 1'b0, 20'h00000, 4'h0, 20'h0},     // R10 writeback cmd ignored
    {1'b0, 2'd1, 1'b0, 20'h00020, 4'h4, 20'h0},     // R5 still E, store hits
    {1'b1, 2'd1, 1'b0, 20'h00000, 4'h1, 20'h0}      // R9 RdX on M flushes
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1";  1: return "R3";  2: return "R2";  3: return "R8";
      4: return "R6";  5: return "R8";  6: return "R9";  7: return "R3";
      8: return "R4";  9: return "R5";  10: return "R7"; 11: return "R10";
      12: return "R5"; 13: return "R9"; 14: return "R10"; 15: return "R3";
      16: return "R10"; 17: return "R5"; default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // starts and ends at a negedge
  task automatic do_cpu(input bit we, input logic [19:0] addr, input bit shin,
                        output bit wb_seen, output logic [19:0] wb_addr, output int cmd_seen);
    wb_seen = 0; wb_addr = '0; cmd_seen = 4;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      bus_grant = 1'b0;
      if (cpu_done) break;
      if (bus_req) begin
        if (bus_cmd == 2'b11) begin
          wb_seen = 1; wb_addr = bus_addr;
        end else begin
          cmd_seen = int'(bus_cmd);
          chk("R2", "request block address", int'(bus_addr), int'(addr & 20'hFFFC0));
        end
        bus_grant = 1'b1; bus_shared_in = shin;
      end
    end
    cpu_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input logic [19:0] addr,
                          output bit sh, output bit fl);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
    #2;
    sh = snp_shared; fl = snp_flush;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit wb, sh, fl;
    logic [19:0] wba;
    int cmd;
    logic [19:0] held;
    do_reset();
    chk("R1", "cpu_done after reset", int'(cpu_done), 0);
    chk("R1", "bus_req after reset", int'(bus_req), 0);
    chk("R1", "snoop outputs after reset", int'({snp_shared, snp_flush}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      if (v[47]) begin
        do_snoop(v[46:45], v[43:24], sh, fl);
        chk(vec_req(i), $sformatf("vector %0d snoop response", i), int'({sh, fl}), int'(v[21:20]));
      end else begin
        do_cpu(v[45], v[43:24], v[44], wb, wba, cmd);
        chk(vec_req(i), $sformatf("vector %0d request command", i), cmd, int'(v[22:20]));
        chk(vec_req(i), $sformatf("vector %0d writeback seen", i), int'(wb), int'(v[23]));
        if (v[23]) chk(vec_req(i), $sformatf("vector %0d victim address", i), int'(wba), int'(v[19:0]));
      end
    end

    // R6: upgrade on Shared line 0x1FF40, invalidated while waiting -> RdX
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 20'h1FF48;
    @(negedge clk);
    chk("R6", "upgrade requested", int'({bus_req, bus_cmd}), int'(3'b110));
    held = bus_addr;
    repeat (2) @(negedge clk);
    chk("R11", "address held while waiting", int'({bus_req, bus_addr}), int'({1'b1, held}));
    do_snoop(2'b01, 20'h1FF40, sh, fl);
    chk("R9", "snoop on waiting Shared line", int'({sh, fl}), 0);
    chk("R6", "request turned into RdX", int'({bus_req, bus_cmd}), int'(3'b101));
    chk("R11", "address after conversion", int'(bus_addr), int'(20'h1FF40));
    bus_grant = 1'b1; bus_shared_in = 1'b0;
    @(negedge clk);
    bus_grant = 1'b0;
    chk("R4", "done after RdX grant", int'(cpu_done), 1);
    cpu_valid = 1'b0;
    @(negedge clk);
    do_snoop(2'b00, 20'h1FF40, sh, fl);
    chk("R8", "line is Modified after RdX", int'({sh, fl}), 3);

    // R1: reset mid-run clears every line
    do_reset();
    do_cpu(1'b0, 20'h1FF40, 1'b0, wb, wba, cmd);
    chk("R1", "miss after reset", cmd, 0);
    chk("R1", "no writeback after reset", int'(wb), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule